// File: doc/BRIEF.md
# Two-Wire Serial Byte-Memory Slave

This block is a two-wire bus target that fronts a byte-wide storage array of 4096 entries. SCL and SDA arrive already synchronized to the system clock. The block pulls SDA low through an open-drain enable and leaves pull-up to the bus. It recognizes START, repeated START and STOP conditions. It decodes a 7-bit device address followed by a direction bit.

A single location pointer survives from one transaction to the next. A write transaction carries a high address byte and a low address byte, then any number of data bytes; each data byte is stored at the pointer, and the pointer then advances. A read transaction streams bytes from the pointer, advancing after each one. The stream continues for as long as the master acknowledges, and the pointer rolls over from the top of the array to zero. To read at a chosen location, the master sends a write that carries only the two address bytes, then a repeated START and a read.

Top module: `i2c_mem_slave`

## Requirements
- R1: A device byte whose upper seven bits equal the parameter DEV_ADDR (default 7'h50) is acknowledged by pulling SDA low during the ninth clock. Bit 0 of that byte selects read (1) or write (0).
- R2: A device byte with a different address gets no acknowledge. The slave then leaves SDA released and ignores the bus, including data bytes, until the next START.
- R3: In a write, the two bytes after the device byte load the pointer, high byte first. Each byte is acknowledged, and the following data bytes are stored.
- R4: Every stored data byte advances the pointer by one, so consecutive data bytes land at consecutive locations.
- R5: A read that is not preceded by an address (current-address read) returns the byte at one past the last location read or written.
- R6: A write that carries only the two address bytes and then ends stores nothing. It only sets the location that the next read returns.
- R7: During a read, each master acknowledge brings the byte at the next location, sent MSB first. A master not-acknowledge ends the read with SDA released.
- R8: The pointer wraps from 4095 to 0 on both reads and writes.
- R9: The bits of the high address byte above the array width (bits 7:4 for 4096 entries) are ignored.
- R10: The slave changes SDA only while SCL is low. It keeps SDA released during the master's acknowledge bit.
- R11: A STOP or START in the middle of a byte abandons that byte without storing it. A START begins a new device-address phase.
- R12: Reset releases SDA and clears the pointer to 0. The array contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl | input | 1 | Synchronized bus clock |
| sda | input | 1 | Synchronized bus data (resolved line level) |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
A wrong pointer value shows up in the very next byte read: a random read, a streamed read or a current-address read returns data from the wrong location. A corrupted bit or byte phase shows within one ninth-clock slot: an acknowledge is missing or misplaced, or SDA moves while SCL is high, and a bus monitor flags that on the cycle it happens. A data byte stored when it should have been dropped after an abort or a mismatched address is caught by reading that location back in the next transaction.

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int AW = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic sda_oe
);
  localparam int HW = AW - 8;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_ADRH, S_ADRL, S_WR, S_RD} st_t;
  st_t st, nxt;

  logic          scl_q, sda_q, ack, mack;
  logic [3:0]    cnt;
  logic [7:0]    sh, tx;
  logic [AW-1:0] ptr;
  logic [7:0]    mem [2**AW];

  wire rise     = scl & ~scl_q;
  wire fall     = ~scl & scl_q;
  wire start_c  = scl & scl_q & sda_q & ~sda;
  wire stop_c   = scl & scl_q & ~sda_q & sda;
  wire byte_end = fall & (cnt == 4'd8) & ~ack;
  wire ack_end  = fall & ack;
  wire ptr_inc  = byte_end & ((st == S_WR) | (st == S_RD));
  wire [7:0] rd_byte = mem[ptr];

  always_ff @(posedge clk)
    if (byte_end && st == S_WR) mem[ptr] <= sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; nxt <= S_IDLE; scl_q <= 1'b1; sda_q <= 1'b1;
      ack <= 1'b0; mack <= 1'b0; cnt <= '0; sh <= '0; tx <= '0;
      ptr <= '0; sda_oe <= 1'b0;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
      if (start_c) begin
        st <= S_DEV; cnt <= '0; ack <= 1'b0; sda_oe <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE; cnt <= '0; ack <= 1'b0; sda_oe <= 1'b0;
      end else if (st != S_IDLE) begin
        if (rise && !ack && cnt < 4'd8) begin
          sh  <= {sh[6:0], sda};
          cnt <= cnt + 4'd1;
        end
        if (rise && ack) mack <= ~sda;
        if (fall && !ack && st == S_RD && cnt != 4'd0 && cnt < 4'd8) begin
          sda_oe <= ~tx[6];
          tx     <= {tx[6:0], 1'b0};
        end
        if (byte_end) begin
          ack <= 1'b1;
          case (st)
            S_DEV:
              if (sh[7:1] == DEV_ADDR) begin
                sda_oe <= 1'b1;
                nxt    <= sh[0] ? S_RD : S_ADRH;
              end else begin
                st <= S_IDLE; ack <= 1'b0; sda_oe <= 1'b0;
              end
            S_ADRH: begin ptr[AW-1:8] <= sh[HW-1:0]; sda_oe <= 1'b1; nxt <= S_ADRL; end
            S_ADRL: begin ptr[7:0] <= sh; sda_oe <= 1'b1; nxt <= S_WR; end
            S_WR:   begin ptr <= ptr + AW'(1); sda_oe <= 1'b1; nxt <= S_WR; end
            S_RD:   begin ptr <= ptr + AW'(1); sda_oe <= 1'b0; nxt <= S_RD; end
            default: ack <= 1'b0;
          endcase
        end
        if (ack_end) begin
          ack <= 1'b0;
          cnt <= '0;
          if (st == S_RD && !mack) begin
            st <= S_IDLE; sda_oe <= 1'b0;
          end else begin
            st <= nxt;
            if (nxt == S_RD) begin
              tx     <= rd_byte;
              sda_oe <= ~rd_byte[7];
            end else sda_oe <= 1'b0;
          end
        end
      end
    end
  end

  p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl);
  p_master_ack_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD && ack) |-> !sda_oe);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);
  p_stop_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (st == S_IDLE && !sda_oe));
  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_inc && ptr == '1) |=> (ptr == '0));
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_inc && ptr != '1) |=> (ptr == $past(ptr) + AW'(1)));
endmodule

// File: tb/i2c_mem_slave_test.sv
module i2c_mem_slave_test;
  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1;
  logic sda_oe;
  wire  sda_bus = m_sda & ~sda_oe;
  int   tests = 0, fails = 0, viol = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  i2c_mem_slave uut (.clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda_bus), .sda_oe(sda_oe));

  logic p_oe = 1'b0, p_scl = 1'b1;
  always @(negedge clk) begin
    if (rst_n && sda_oe != p_oe && scl && p_scl) viol++;
    p_oe  <= sda_oe;
    p_scl <= scl;
  end

  task automatic q(); repeat (4) @(negedge clk); endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_start(); m_sda = 1; q(); scl = 1; q(); m_sda = 0; q(); scl = 0; q(); endtask
  task automatic bus_stop();  m_sda = 0; q(); scl = 1; q(); m_sda = 1; q(); endtask
  task automatic send_bit(input logic b); m_sda = b; q(); scl = 1; q(); q(); scl = 0; q(); endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1; q(); scl = 1; q(); acked = ~sda_bus; q(); scl = 0; q();
  endtask

  task automatic read_byte(input logic give_ack, output logic [7:0] d);
    m_sda = 1;
    for (int i = 0; i < 8; i++) begin
      q(); scl = 1; q(); d = {d[6:0], sda_bus}; q(); scl = 0;
    end
    q(); m_sda = ~give_ack; q(); scl = 1; q();
    chk("R10 slave releases during master ack", {15'd0, sda_oe}, 16'd0);
    q(); scl = 0; q(); m_sda = 1;
  endtask

  task automatic set_addr(input logic [15:0] a);
    logic k;
    bus_start();
    send_byte(8'hA0, k); chk("R1 device write ack", {15'd0, k}, 16'd1);
    send_byte(a[15:8], k); chk("R3 high addr ack", {15'd0, k}, 16'd1);
    send_byte(a[7:0], k);  chk("R3 low addr ack", {15'd0, k}, 16'd1);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d [4], input int n);
    logic k;
    set_addr(a);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], k); chk("R3 data ack", {15'd0, k}, 16'd1);
    end
    bus_stop();
  endtask

  task automatic rd_stream(output logic [7:0] d [4], input int n);
    logic k;
    bus_start();
    send_byte(8'hA1, k); chk("R1 device read ack", {15'd0, k}, 16'd1);
    for (int i = 0; i < n; i++) read_byte(i != n - 1, d[i]);
    bus_stop();
  endtask

  task automatic rd_rand(input logic [15:0] a, output logic [7:0] d [4], input int n);
    set_addr(a);
    rd_stream(d, n);
  endtask

  task automatic do_reset(); rst_n = 0; repeat (5) @(negedge clk); rst_n = 1; q(); endtask

  task automatic t_reset();
    do_reset();
    chk("R12 SDA released after reset", {15'd0, sda_oe}, 16'd0);
  endtask

  task automatic t_write_stream();
    logic [7:0] d [4];
    wr(16'h0123, '{8'hAA, 8'h55, 8'hC3, 8'h00}, 3);
    rd_rand(16'h0123, d, 3);
    chk("R4 first byte", {8'd0, d[0]}, 16'h00AA);
    chk("R7 streamed second", {8'd0, d[1]}, 16'h0055);
    chk("R7 streamed third", {8'd0, d[2]}, 16'h00C3);
  endtask

  task automatic t_current();
    logic [7:0] d [4];
    wr(16'h0200, '{8'h11, 8'h22, 8'h0, 8'h0}, 2);
    rd_rand(16'h0200, d, 1);
    chk("R6 random read", {8'd0, d[0]}, 16'h0011);
    rd_stream(d, 1);
    chk("R5 current after read", {8'd0, d[0]}, 16'h0022);
    wr(16'h0301, '{8'h99, 8'h0, 8'h0, 8'h0}, 1);
    wr(16'h0300, '{8'h77, 8'h0, 8'h0, 8'h0}, 1);
    rd_stream(d, 1);
    chk("R5 current after write", {8'd0, d[0]}, 16'h0099);
  endtask

  task automatic t_addr_only();
    logic [7:0] d [4];
    wr(16'h0050, '{8'h5A, 8'h0, 8'h0, 8'h0}, 1);
    set_addr(16'h0050); bus_stop();
    rd_rand(16'h0050, d, 1);
    chk("R6 address-only write stores nothing", {8'd0, d[0]}, 16'h005A);
  endtask

  task automatic t_nomatch();
    logic k;
    logic [7:0] d [4];
    bus_start();
    send_byte(8'hA2, k); chk("R2 no ack on other address", {15'd0, k}, 16'd0);
    send_byte(8'h00, k); chk("R2 ignored byte", {15'd0, k}, 16'd0);
    send_byte(8'h50, k);
    send_byte(8'hFF, k); chk("R2 ignored data", {15'd0, k}, 16'd0);
    bus_stop();
    rd_rand(16'h0050, d, 1);
    chk("R2 memory untouched", {8'd0, d[0]}, 16'h005A);
  endtask

  task automatic t_wrap();
    logic [7:0] d [4];
    wr(16'h0FFF, '{8'hE1, 8'hE2, 8'h0, 8'h0}, 2);
    rd_rand(16'h0000, d, 1);
    chk("R8 write wrapped to 0", {8'd0, d[0]}, 16'h00E2);
    rd_rand(16'h0FFF, d, 2);
    chk("R8 read top", {8'd0, d[0]}, 16'h00E1);
    chk("R8 read wrapped", {8'd0, d[1]}, 16'h00E2);
  endtask

  task automatic t_hi_ignore();
    logic [7:0] d [4];
    wr(16'hF044, '{8'h3C, 8'h0, 8'h0, 8'h0}, 1);
    rd_rand(16'h0044, d, 1);
    chk("R9 upper high-address bits ignored", {8'd0, d[0]}, 16'h003C);
  endtask

  task automatic t_abort();
    logic k;
    logic [7:0] d [4];
    wr(16'h0060, '{8'h61, 8'h0, 8'h0, 8'h0}, 1);
    set_addr(16'h0060);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    rd_rand(16'h0060, d, 1);
    chk("R11 STOP mid-byte drops byte", {8'd0, d[0]}, 16'h0061);
    set_addr(16'h0060);
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    bus_start();
    send_byte(8'hA1, k); chk("R11 START mid-byte re-decodes", {15'd0, k}, 16'd1);
    read_byte(1'b0, d[0]);
    bus_stop();
    chk("R11 START mid-byte drops byte", {8'd0, d[0]}, 16'h0061);
  endtask

  task automatic t_reset_ptr();
    logic [7:0] d [4];
    do_reset();
    rd_stream(d, 1);
    chk("R12 pointer cleared, array kept", {8'd0, d[0]}, 16'h00E2);
  endtask

  initial begin
    t_reset();
    t_write_stream();
    t_current();
    t_addr_only();
    t_nomatch();
    t_wrap();
    t_hi_ignore();
    t_abort();
    t_reset_ptr();
    chk("R10 SDA stable while SCL high", viol[15:0], 16'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule